// File: doc/BRIEF.md
# Command-Mode Panel Bus Bridge

This block sits between a 32-bit register bus and one or two command-mode display panels that share a 16-bit parallel data bus. Each panel has its own active-low chip select; a register-select line (A0) tells the panel whether a word is a command (A0 low) or a parameter/pixel word (A0 high). Software picks the target panels in a control register. It then writes command, parameter or pixel words, or writes one of two read triggers that fetch a word from a panel into a receive buffer.

A pixel counter that software loads counts down on every pixel write and every panel read. A frame transfer is started through the control register. It stays busy until the counter reaches zero, and then the block clears busy and gives a one-cycle frame-done pulse. The panel timing registers are storage only. The bus cadence is fixed: one strobe clock per word, then one idle clock.

Top module: `panel_bridge`

## Requirements
- R1: After reset the control register reads 0, both config registers read 0x00310000, the status register reads 0x1 (bit 0 always 1, bit 8 busy = 0) and all strobes and chip selects are high.
- R2: The control register (offset 0x04) keeps bits 3:0 only. The config registers (0x24, 0x28) keep only bits under 0x003F1FFF. The line register (0x0C) keeps 11 bits.
- R3: A write to the command offset (0x10) drives bits 15:0 with A0 low to every panel selected in control (bit 2 = panel 0 on pb_cs_n[0], bit 3 = panel 1 on pb_cs_n[1]).
- R4: A write to the parameter offset (0x14) drives bits 15:0 with A0 high to every selected panel.
- R5: A write to the pixel offset (0x18) drives bits 15:0 and then bits 31:16, both with A0 high, and decrements the pixel counter (0x08) when it is non-zero.
- R6: Each bus word holds its strobe low for exactly one clock, with chip selects low only during a strobe, and one idle clock follows each word.
- R7: A write to offset 0x1C reads one panel word with A0 high, and a write to 0x20 reads one with A0 low. Panel 0 alone is read when both are selected. The word lands in a receive buffer that reads back at either offset, and the pixel counter decrements.
- R8: A control write with bit 4 and bit 0 set starts a transfer (status bit 8 = 1) when no transfer is busy and the AND of the two config registers has bits 3:2 both zero.
- R9: When the pixel counter steps from 1 to 0 during a transfer, busy clears and frame_done pulses high for one clock.
- R10: A start request is ignored when bit 0 of the written value is 0, when a transfer is already busy, or when the config registers block it.
- R11: A panel access (0x10 to 0x20) written while seq_active is high is dropped. It produces no bus word and does not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| seq_active | output | 1 | Panel bus sequence in progress |
| frame_done | output | 1 | One-clock pulse at end of transfer |
| pb_dout | output | 16 | Panel bus write data |
| pb_oe | output | 1 | Panel bus output enable |
| pb_din | input | 16 | Panel bus read data |
| pb_a0 | output | 1 | Command (0) / data (1) select |
| pb_wr_n | output | 1 | Write strobe, active low |
| pb_rd_n | output | 1 | Read strobe, active low |
| pb_cs_n | output | 2 | Panel chip selects, active low |

## Verification
The hardest case to reach is a panel access that arrives while the sequencer is still running a previous word. To create it, the stimulus issues two register writes on consecutive clocks. The scoreboard must then see only the first access's words, and the pixel counter must drop by one only. A second hard corner is a start request while a transfer is already busy. The bench starts a transfer, repeats the start mid-transfer, and then checks that busy ends on the original count and that exactly one frame-done pulse appears.

// File: rtl/pnl_pkg.sv
// Shared types and register map for the panel bus bridge.
package pnl_pkg;
    typedef enum logic [1:0] {OP_WR1, OP_WR2, OP_RD} pnl_op_e;

    localparam int OFS_STAT  = 'h00;
    localparam int OFS_CTRL  = 'h04;
    localparam int OFS_PIX   = 'h08;
    localparam int OFS_LINE  = 'h0C;
    localparam int OFS_CMD   = 'h10;
    localparam int OFS_PARAM = 'h14;
    localparam int OFS_DATA  = 'h18;
    localparam int OFS_RDD   = 'h1C;
    localparam int OFS_RDS   = 'h20;
    localparam int OFS_CFG0  = 'h24;
    localparam int OFS_CFG1  = 'h28;
    localparam int OFS_TIM0  = 'h2C;
    localparam int OFS_TIM1  = 'h30;

    localparam logic [31:0] CFG_RESET = 32'h0031_0000;
    localparam logic [31:0] CFG_MASK  = 32'h003F_1FFF;
endpackage

// File: rtl/pnl_regs.sv
// Register file, pixel counter and transfer-busy tracking.
// Assumes: panel accesses are accepted only while the sequencer is idle.
module pnl_regs
    import pnl_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int PIX_W  = 16,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              seq_active,
    input  logic              rx_valid,
    input  logic [15:0]       rx_data,
    output logic              req_valid,
    output pnl_op_e           req_op,
    output logic              req_a0,
    output logic [1:0]        req_sel,
    output logic              busy,
    output logic              frame_done
);
    logic [3:0]        ctrl;
    logic [PIX_W-1:0]  pixcnt;
    logic [LINE_W-1:0] line_no;
    logic [31:0]       cfg [2];
    logic [31:0]       tim [2];
    logic [15:0]       rxbuf;
    logic              is_panel_acc;
    logic              dec_req;
    logic              start_ok;

    // Decode panel-access offsets and build the sequencer request.
    always_comb begin
        is_panel_acc = 1'b0;
        req_op       = OP_WR1;
        req_a0       = 1'b1;
        dec_req      = 1'b0;
        case (addr)
            ADDR_W'(OFS_CMD):   begin is_panel_acc = 1'b1; req_a0 = 1'b0; end
            ADDR_W'(OFS_PARAM): begin is_panel_acc = 1'b1; end
            ADDR_W'(OFS_DATA):  begin is_panel_acc = 1'b1; req_op = OP_WR2; dec_req = 1'b1; end
            ADDR_W'(OFS_RDD):   begin is_panel_acc = 1'b1; req_op = OP_RD; dec_req = 1'b1; end
            ADDR_W'(OFS_RDS):   begin is_panel_acc = 1'b1; req_op = OP_RD; req_a0 = 1'b0; dec_req = 1'b1; end
            default: ;
        endcase
        req_valid = wr_en && is_panel_acc && !seq_active;
        req_sel   = (req_op == OP_RD && ctrl[3:2] == 2'b11) ? 2'b01 : ctrl[3:2];
        start_ok  = ((cfg[0][3:2] & cfg[1][3:2]) == 2'b00);
    end

    // Register updates, counter decrement and transfer completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl       <= '0;
            pixcnt     <= '0;
            line_no    <= '0;
            cfg[0]     <= CFG_RESET;
            cfg[1]     <= CFG_RESET;
            tim[0]     <= '0;
            tim[1]     <= '0;
            rxbuf      <= '0;
            busy       <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (rx_valid)
                rxbuf <= rx_data;
            if (wr_en) begin
                case (addr)
                    ADDR_W'(OFS_CTRL): begin
                        ctrl <= wdata[3:0];
                        if (wdata[4] && wdata[0] && !busy && start_ok)
                            busy <= 1'b1;
                    end
                    ADDR_W'(OFS_PIX):  pixcnt  <= wdata[PIX_W-1:0];
                    ADDR_W'(OFS_LINE): line_no <= wdata[LINE_W-1:0];
                    ADDR_W'(OFS_CFG0): cfg[0]  <= wdata & CFG_MASK;
                    ADDR_W'(OFS_CFG1): cfg[1]  <= wdata & CFG_MASK;
                    ADDR_W'(OFS_TIM0): tim[0]  <= wdata;
                    ADDR_W'(OFS_TIM1): tim[1]  <= wdata;
                    default: ;
                endcase
            end
            if (req_valid && dec_req && pixcnt != '0) begin
                pixcnt <= pixcnt - 1'b1;
                if (pixcnt == PIX_W'(1) && busy) begin
                    busy       <= 1'b0;
                    frame_done <= 1'b1;
                end
            end
        end
    end

    // Read-back multiplexer.
    always_comb begin
        case (addr)
            ADDR_W'(OFS_STAT): rdata = {23'd0, busy, 7'd0, 1'b1};
            ADDR_W'(OFS_CTRL): rdata = {28'd0, ctrl};
            ADDR_W'(OFS_PIX):  rdata = 32'(pixcnt);
            ADDR_W'(OFS_LINE): rdata = 32'(line_no);
            ADDR_W'(OFS_RDD),
            ADDR_W'(OFS_RDS):  rdata = {16'd0, rxbuf};
            ADDR_W'(OFS_CFG0): rdata = cfg[0];
            ADDR_W'(OFS_CFG1): rdata = cfg[1];
            ADDR_W'(OFS_TIM0): rdata = tim[0];
            ADDR_W'(OFS_TIM1): rdata = tim[1];
            default:           rdata = '0;
        endcase
    end
endmodule

// File: rtl/pnl_seq.sv
// Panel bus sequencer: one strobe clock per word, one idle clock after it.
// Assumes: req_valid only arrives while the sequencer is idle.
module pnl_seq
    import pnl_pkg::*;
#(
    parameter int NPANEL = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  pnl_op_e           req_op,
    input  logic              req_a0,
    input  logic [NPANEL-1:0] req_sel,
    input  logic [31:0]       req_data,
    output logic              active,
    output logic              rx_valid,
    output logic [15:0]       rx_data,
    output logic [15:0]       pb_dout,
    output logic              pb_oe,
    input  logic [15:0]       pb_din,
    output logic              pb_a0,
    output logic              pb_wr_n,
    output logic              pb_rd_n,
    output logic [NPANEL-1:0] pb_cs_n
);
    typedef enum logic [2:0] {S_IDLE, S_WSTB, S_WGAP, S_RSTB, S_RGAP} seq_st_e;
    seq_st_e           st;
    logic [15:0]       data_q;
    logic [15:0]       hi_q;
    logic              second_q;
    logic              a0_q;
    logic [NPANEL-1:0] sel_q;
    logic              stb;

    // Step through strobe and gap states, one word at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            data_q   <= '0;
            hi_q     <= '0;
            second_q <= 1'b0;
            a0_q     <= 1'b0;
            sel_q    <= '0;
        end else begin
            case (st)
                S_IDLE: if (req_valid) begin
                    data_q   <= req_data[15:0];
                    hi_q     <= req_data[31:16];
                    second_q <= (req_op == OP_WR2);
                    a0_q     <= req_a0;
                    sel_q    <= req_sel;
                    st       <= (req_op == OP_RD) ? S_RSTB : S_WSTB;
                end
                S_WSTB: st <= S_WGAP;
                S_WGAP: begin
                    if (second_q) begin
                        data_q   <= hi_q;
                        second_q <= 1'b0;
                        st       <= S_WSTB;
                    end else begin
                        st <= S_IDLE;
                    end
                end
                S_RSTB: st <= S_RGAP;
                default: st <= S_IDLE;
            endcase
        end
    end

    assign stb      = (st == S_WSTB) || (st == S_RSTB);
    assign active   = (st != S_IDLE);
    assign rx_valid = (st == S_RSTB);
    assign rx_data  = pb_din;
    assign pb_dout  = data_q;
    assign pb_oe    = (st == S_WSTB);
    assign pb_a0    = a0_q;
    assign pb_wr_n  = !(st == S_WSTB);
    assign pb_rd_n  = !(st == S_RSTB);

    // One chip select per panel, low only during a strobe.
    for (genvar p = 0; p < NPANEL; p++) begin : g_cs
        assign pb_cs_n[p] = !(stb && sel_q[p]);
    end
endmodule

// File: rtl/panel_bridge.sv
// Top: register bus to shared 16-bit command-mode panel bus, two panels.
// Assumes: a single clock domain; reg_rdata follows reg_addr combinationally.
module panel_bridge
    import pnl_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int PIX_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              seq_active,
    output logic              frame_done,
    output logic [15:0]       pb_dout,
    output logic              pb_oe,
    input  logic [15:0]       pb_din,
    output logic              pb_a0,
    output logic              pb_wr_n,
    output logic              pb_rd_n,
    output logic [1:0]        pb_cs_n
);
    localparam int NPANEL = 2;

    logic              req_valid;
    pnl_op_e           req_op;
    logic              req_a0;
    logic [NPANEL-1:0] req_sel;
    logic              rx_valid;
    logic [15:0]       rx_data;
    logic              xfer_busy;

    pnl_regs #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .seq_active(seq_active),
        .rx_valid(rx_valid), .rx_data(rx_data), .req_valid(req_valid),
        .req_op(req_op), .req_a0(req_a0), .req_sel(req_sel),
        .busy(xfer_busy), .frame_done(frame_done)
    );

    pnl_seq #(.NPANEL(NPANEL)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_a0(req_a0), .req_sel(req_sel), .req_data(reg_wdata),
        .active(seq_active), .rx_valid(rx_valid), .rx_data(rx_data),
        .pb_dout(pb_dout), .pb_oe(pb_oe), .pb_din(pb_din), .pb_a0(pb_a0),
        .pb_wr_n(pb_wr_n), .pb_rd_n(pb_rd_n), .pb_cs_n(pb_cs_n)
    );
endmodule

// File: rtl/panel_bridge_chk.sv
// Protocol checker for panel_bridge, attached by bind.
module panel_bridge_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pb_wr_n,
    input logic       pb_rd_n,
    input logic [1:0] pb_cs_n,
    input logic       frame_done,
    input logic       xfer_busy
);
    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pb_wr_n || pb_rd_n);
    // R6
    wr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pb_wr_n |=> pb_wr_n);
    // R6
    rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pb_rd_n |=> pb_rd_n);
    // R6
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_cs_n != 2'b11) |-> (!pb_wr_n || !pb_rd_n));
    // R7
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pb_rd_n |-> ($countones(~pb_cs_n) <= 1));
    // R9
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (!xfer_busy && $past(xfer_busy)));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
endmodule

bind panel_bridge panel_bridge_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pb_wr_n(pb_wr_n), .pb_rd_n(pb_rd_n),
    .pb_cs_n(pb_cs_n), .frame_done(frame_done), .xfer_busy(xfer_busy)
);

// File: tb/sim_panel_bridge.sv
`timescale 1ns/1ps
module sim_panel_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        seq_active, frame_done, pb_oe, pb_a0, pb_wr_n, pb_rd_n;
    logic [15:0] pb_dout;
    logic [15:0] pb_din = 16'h0000;
    logic [1:0]  pb_cs_n;

    int errors = 0;
    int checks = 0;
    int done_cnt = 0;
    bit finished = 0;
    // item: {is_read, a0, cs_n[1:0], data[15:0]}
    logic [19:0] expq [$];

    always #10 clk = ~clk;

    panel_bridge u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_active(seq_active),
        .frame_done(frame_done), .pb_dout(pb_dout), .pb_oe(pb_oe),
        .pb_din(pb_din), .pb_a0(pb_a0), .pb_wr_n(pb_wr_n), .pb_rd_n(pb_rd_n),
        .pb_cs_n(pb_cs_n)
    );

    // Monitor: pop one expected item per observed strobe clock.
    always @(negedge clk) begin
        if (rst_n && frame_done) done_cnt++;
        if (rst_n && (!pb_wr_n || !pb_rd_n)) begin
            logic [19:0] got;
            got = {!pb_rd_n, pb_a0, pb_cs_n, (!pb_rd_n) ? 16'h0 : pb_dout};
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R11 unexpected bus word got=%h expected=none", got);
            end else begin
                logic [19:0] e;
                e = expq.pop_front();
                if (got !== e) begin
                    errors++;
                    $display("FAIL R3/R4/R5/R7 bus word got=%h expected=%h", got, e);
                end
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic idle();
        while (seq_active) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic [5:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s reg %h got=%h expected=%h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_val(input logic [31:0] got, input logic [31:0] exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic push(input logic rd, input logic a0, input logic [1:0] cs, input logic [15:0] d);
        expq.push_back({rd, a0, cs, d});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(6'h04, 32'h0, "R1");
        chk(6'h24, 32'h0031_0000, "R1");
        chk(6'h28, 32'h0031_0000, "R1");
        chk(6'h00, 32'h1, "R1");
        chk_val({30'd0, pb_wr_n, pb_rd_n}, 32'h3, "R1 strobes");
        chk_val({30'd0, pb_cs_n}, 32'h3, "R1 cs");
        // R2 masks
        wr(6'h04, 32'hFFFF_FFEE); chk(6'h04, 32'hE, "R2");
        wr(6'h24, 32'hFFFF_FFFF); chk(6'h24, 32'h003F_1FFF, "R2");
        wr(6'h0C, 32'h0000_FFFF); chk(6'h0C, 32'h7FF, "R2");
        wr(6'h24, 32'h0);
        // R3 command to panel 0
        wr(6'h04, 32'h4);
        push(0, 0, 2'b10, 16'h1234);
        wr(6'h10, 32'hABCD_1234); idle();
        // R4 parameter to both panels
        wr(6'h04, 32'hC);
        push(0, 1, 2'b00, 16'h5A5A);
        wr(6'h14, 32'h0000_5A5A); idle();
        // R5 pixel word: low half first, counter down
        wr(6'h08, 32'd5);
        push(0, 1, 2'b00, 16'h1111);
        push(0, 1, 2'b00, 16'h2222);
        wr(6'h18, 32'h2222_1111); idle();
        chk(6'h08, 32'd4, "R5");
        // R7 read with both panels: panel 0 only, A0 high
        pb_din = 16'hBEEF;
        push(1, 1, 2'b10, 16'h0);
        wr(6'h1C, 32'h0); idle();
        chk(6'h1C, 32'h0000_BEEF, "R7");
        chk(6'h08, 32'd3, "R7");
        // R7 status read from panel 1, A0 low
        wr(6'h04, 32'h8);
        pb_din = 16'h1357;
        push(1, 0, 2'b01, 16'h0);
        wr(6'h20, 32'h0); idle();
        chk(6'h20, 32'h0000_1357, "R7");
        // R11 back-to-back accesses: second is dropped
        wr(6'h04, 32'h4);
        wr(6'h08, 32'd2);
        push(0, 1, 2'b10, 16'h0001);
        push(0, 1, 2'b10, 16'h0002);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 6'h18; reg_wdata = 32'h0002_0001;
        @(negedge clk);
        reg_wdata = 32'h0004_0003;
        @(negedge clk);
        reg_wr_en = 1'b0;
        idle();
        chk(6'h08, 32'd1, "R11");
        chk_val(32'(expq.size()), 32'd0, "R11 queue drained");
        // R10 start while disabled
        wr(6'h04, 32'h14); chk(6'h00, 32'h1, "R10 disabled");
        // R10 start blocked by config
        wr(6'h24, 32'h4); wr(6'h28, 32'h4);
        wr(6'h04, 32'h15); chk(6'h00, 32'h1, "R10 cfg block");
        wr(6'h28, 32'h0);
        // R8 start
        wr(6'h08, 32'd2);
        wr(6'h04, 32'h15); chk(6'h00, 32'h101, "R8");
        // R10 restart while busy has no effect
        wr(6'h04, 32'h15); chk(6'h08, 32'd2, "R10 busy");
        push(0, 1, 2'b10, 16'hAAAA); push(0, 1, 2'b10, 16'hBBBB);
        wr(6'h18, 32'hBBBB_AAAA); idle();
        chk(6'h00, 32'h101, "R9 still busy");
        push(0, 1, 2'b10, 16'hCCCC); push(0, 1, 2'b10, 16'hDDDD);
        wr(6'h18, 32'hDDDD_CCCC); idle();
        chk(6'h00, 32'h1, "R9 busy cleared");
        chk_val(32'(done_cnt), 32'd1, "R9 frame_done");
        // R5 counter at zero stays zero, no extra frame_done
        push(0, 1, 2'b10, 16'h0E0E); push(0, 1, 2'b10, 16'h0F0F);
        wr(6'h18, 32'h0F0F_0E0E); idle();
        chk(6'h08, 32'd0, "R5 zero hold");
        chk_val(32'(done_cnt), 32'd1, "R9 single pulse");
        chk_val(32'(expq.size()), 32'd0, "R3 queue drained");
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog got=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule